// File: doc/BRIEF.md
# Serial EEPROM Byte Access Sequencer

This block sits between a host request port and a byte-wide SPI master. It turns one request (read or write, a 16-bit address and, for a write, one data byte) into the exact series of chip-select frames and byte transfers that a serial EEPROM expects. Each byte is sent by pulsing a start strobe with the byte to send. The SPI master answers with a done strobe and the byte it received during that transfer. The next byte is not sent until that done strobe arrives.

A write is spread over several frames, each framed by its own chip-select low period. The first frame unlocks the device for writing. The second carries the opcode, the address and the data. Then come repeated status polls until the device reports it is idle. The last frame locks the device again. A read fits in one frame: the read opcode and address are sent, then a zero filler byte, and the byte received during the filler is returned. Between frames, chip select stays high for a parameterised minimum number of clocks. A parameterised poll limit ends a write that never finishes and reports a timeout.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset and whenever idle, `cs_no` is 1, `busy_o` is 0, `done_o` is 0 and `spi_start_o` is 0.
- R2: A request is taken only while `busy_o` is 0. `busy_o` is 1 from the cycle after acceptance through the `done_o` cycle and 0 in the cycle after it. A `req_valid_i` seen while busy has no effect on the frames sent or on the result.
- R3: A write opens with a frame that holds the single byte 0x06.
- R4: The second write frame holds, in order, 0x02, address bits 15:8, address bits 7:0 and the data byte, all in one chip-select low period.
- R5: After the data frame, status frames of two bytes (0x05, then filler 0x00) repeat. Bit 0 of the byte received during the filler is the busy flag. Polling stops at the first frame where that bit is 0.
- R6: A write ends with a frame holding the single byte 0x04, after which `done_o` is raised.
- R7: A read is one frame of 0x03, address bits 15:8, address bits 7:0 and filler 0x00. The byte received during the filler appears on `rdata_o` in the `done_o` cycle.
- R8: `spi_start_o` is raised only while `cs_no` is 0, for one cycle per byte, and never again before `spi_done_i` has answered the previous byte.
- R9: Between two frames, `cs_no` stays 1 for at least `CS_GAP` clock cycles.
- R10: If `POLL_MAX` status frames in a row all report busy, polling stops and the 0x04 frame is still sent. `done_o` then comes with `timeout_o` = 1. `timeout_o` is 0 outside that case.
- R11: `done_o` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | 8 | Read result, valid with `done_o` |
| timeout_o | output | 1 | Write poll limit reached, valid with `done_o` |
| cs_no | output | 1 | Device chip select, active low |
| spi_start_o | output | 1 | Start one byte transfer |
| spi_tx_o | output | 8 | Byte to send, valid with `spi_start_o` |
| spi_done_i | input | 1 | Byte transfer finished |
| spi_rx_i | input | 8 | Byte received, valid with `spi_done_i` |

## Verification
The bench builds the block with `CS_GAP` = 3, so the minimum high time spans more than one cycle and the gap counter really counts down. It uses `POLL_MAX` = 5, so the poll limit is reached within a few frames. A write whose device model stays busy for exactly four polls completes normally, and one that stays busy for five times out. Transfer latency from the SPI master model varies at random, which exercises the wait on `spi_done_i` at different depths.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_START, ST_WAIT, ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    FR_UNLOCK, FR_PROG, FR_POLL, FR_LOCK, FR_FETCH
  } frame_e;

  localparam logic [7:0] OP_UNLOCK = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_STAT   = 8'h05;
  localparam logic [7:0] OP_LOCK   = 8'h04;
  localparam logic [7:0] OP_FETCH  = 8'h03;
  localparam logic [7:0] FILLER    = 8'h00;

  function automatic logic [1:0] frame_last(frame_e f);
    case (f)
      FR_PROG, FR_FETCH: frame_last = 2'd3;
      FR_POLL:           frame_last = 2'd1;
      default:           frame_last = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/seq_byte_sel.sv
module seq_byte_sel
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  frame_e            frame_i,
  input  logic [1:0]        idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        byte_o,
  output logic              last_o
);

  localparam int ABYTES = ADDR_W / 8;

  logic [7:0] addr_hi, addr_lo;
  assign addr_hi = addr_i[ADDR_W-1 -: 8];
  assign addr_lo = addr_i[7:0];

  always_comb begin
    byte_o = FILLER;
    case (frame_i)
      FR_UNLOCK: byte_o = OP_UNLOCK;
      FR_LOCK:   byte_o = OP_LOCK;
      FR_POLL:   byte_o = (idx_i == 2'd0) ? OP_STAT : FILLER;
      FR_PROG, FR_FETCH: begin
        case (idx_i)
          2'd0:    byte_o = (frame_i == FR_PROG) ? OP_PROG : OP_FETCH;
          2'd1:    byte_o = addr_hi;
          2'd2:    byte_o = addr_lo;
          default: byte_o = (frame_i == FR_PROG) ? wdata_i : FILLER;
        endcase
      end
      default:   byte_o = FILLER;
    endcase
  end

  assign last_o = (idx_i == frame_last(frame_i));

  initial begin
    addr_width_chk: assert (ABYTES == 2);
  end

endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
  parameter int GAP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);

  localparam int GW = (GAP < 2) ? 1 : $clog2(GAP + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= GW'(GAP - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/seq_poll_limit.sv
module seq_poll_limit #(
  parameter int POLL_MAX = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);

  localparam int PW = $clog2(POLL_MAX + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // current poll is the POLL_MAX-th
  assign at_limit_o = (cnt_q == PW'(POLL_MAX - 1));

endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CS_GAP   = 4,
  parameter int POLL_MAX = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic              timeout_o,
  output logic              cs_no,
  output logic              spi_start_o,
  output logic [7:0]        spi_tx_o,
  input  logic              spi_done_i,
  input  logic [7:0]        spi_rx_i
);

  localparam int HW = $clog2(CS_GAP + 1);

  seq_state_e        state_q, state_d;
  frame_e            frame_q, frame_d;
  logic [1:0]        idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q, rdata_q;
  logic              tout_q, tout_d;
  logic              accept, gap_load, gap_expired;
  logic              poll_inc, poll_at_limit;
  logic              byte_last;
  logic [7:0]        byte_tx;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  seq_byte_sel #(.ADDR_W(ADDR_W)) i_byte_sel (
    .frame_i (frame_q),
    .idx_i   (idx_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .byte_o  (byte_tx),
    .last_o  (byte_last)
  );

  seq_gap_timer #(.GAP(CS_GAP)) i_gap_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gap_load),
    .expired_o (gap_expired)
  );

  seq_poll_limit #(.POLL_MAX(POLL_MAX)) i_poll_limit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .inc_i      (poll_inc),
    .at_limit_o (poll_at_limit)
  );

  always_comb begin
    state_d  = state_q;
    frame_d  = frame_q;
    idx_d    = idx_q;
    tout_d   = tout_q;
    gap_load = 1'b0;
    poll_inc = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        frame_d  = req_write_i ? FR_UNLOCK : FR_FETCH;
        idx_d    = '0;
        tout_d   = 1'b0;
        gap_load = 1'b1;
        state_d  = ST_GAP;
      end
      ST_GAP:   if (gap_expired) state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT: if (spi_done_i) begin
        if (!byte_last) begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_START;
        end else begin
          idx_d    = '0;
          gap_load = 1'b1;
          state_d  = ST_GAP;
          case (frame_q)
            FR_UNLOCK: frame_d = FR_PROG;
            FR_PROG:   frame_d = FR_POLL;
            FR_POLL: begin
              if (!spi_rx_i[0]) begin
                frame_d = FR_LOCK;
              end else if (poll_at_limit) begin
                frame_d = FR_LOCK;
                tout_d  = 1'b1;
              end else begin
                poll_inc = 1'b1;
              end
            end
            default: begin
              gap_load = 1'b0;
              state_d  = ST_DONE;
            end
          endcase
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      frame_q <= FR_UNLOCK;
      idx_q   <= '0;
      tout_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      idx_q   <= idx_d;
      tout_q  <= tout_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (state_q == ST_WAIT && spi_done_i && byte_last && frame_q == FR_FETCH)
        rdata_q <= spi_rx_i;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign timeout_o   = done_o && tout_q;
  assign rdata_o     = rdata_q;
  assign cs_no       = !((state_q == ST_START) || (state_q == ST_WAIT));
  assign spi_start_o = (state_q == ST_START);
  assign spi_tx_o    = byte_tx;

  // checker state: consecutive cycles with chip select high
  logic [HW-1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_run_q <= '0;
    else if (!cs_no)                 hi_run_q <= '0;
    else if (hi_run_q != HW'(CS_GAP)) hi_run_q <= hi_run_q + 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !spi_start_o && !done_o));
  // R2
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R2
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R8
  start_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o |-> !cs_no);
  // R8
  start_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o |=> !spi_start_o);
  // R9
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_run_q >= HW'(CS_GAP)));
  // R10
  tout_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/test_spi_eeprom_seq.sv
`timescale 1ns/1ps
module test_spi_eeprom_seq;

  localparam int CS_GAP   = 3;
  localparam int POLL_MAX = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic busy_o, done_o, timeout_o, cs_no, spi_start_o;
  logic [7:0] rdata_o, spi_tx_o;
  logic spi_done_i = 1'b0;
  logic [7:0] spi_rx_i = '0;

  always #2 clk_i = ~clk_i;

  spi_eeprom_seq #(.ADDR_W(16), .CS_GAP(CS_GAP), .POLL_MAX(POLL_MAX)) i_spi_eeprom_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .busy_o, .done_o, .rdata_o, .timeout_o, .cs_no, .spi_start_o, .spi_tx_o,
    .spi_done_i, .spi_rx_i
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // device + SPI master model
  logic [7:0] mem [256];
  logic [7:0] act_b [64];
  int act_len [16];
  int act_nfr = 0, act_nb = 0;
  bit frame_open = 0, wel = 0, pending = 0, proto_err = 0;
  int busy_left = 0, cfg_busy = 0, dcnt = 0, pos = 0, hi_run = 0;
  logic [7:0] cur_op, resp, ahi, alo;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      spi_done_i = 1'b0;
      if (pending) begin
        if (dcnt == 0) begin
          spi_done_i = 1'b1;
          spi_rx_i = resp;
          pending = 0;
        end else dcnt--;
      end
      if (cs_no && frame_open) begin
        frame_open = 0;
        if (cur_op == 8'h06) wel = 1;
        if (cur_op == 8'h04) wel = 0;
      end
      // R9 gap measured at every chip-select fall
      if (!cs_no && hi_run > 0) begin
        chk(hi_run >= CS_GAP, "R9", "cs high run", hi_run, CS_GAP);
        hi_run = 0;
      end
      if (cs_no) hi_run++;
      if (spi_start_o) begin
        if (cs_no || pending) proto_err = 1;
        if (!frame_open) begin
          frame_open = 1;
          pos = 0;
          if (act_nfr < 16) act_len[act_nfr] = 0;
          act_nfr++;
        end
        if (act_nb < 64) act_b[act_nb] = spi_tx_o;
        act_nb++;
        if (act_nfr <= 16) act_len[act_nfr-1]++;
        resp = 8'h00;
        if (pos == 0) cur_op = spi_tx_o;
        if (pos == 1) ahi = spi_tx_o;
        if (pos == 2) alo = spi_tx_o;
        if (cur_op == 8'h05 && pos == 1) begin
          resp = {7'd0, busy_left > 0};
          if (busy_left > 0) busy_left--;
        end
        if (cur_op == 8'h03 && pos == 3) resp = mem[alo];
        if (cur_op == 8'h02 && pos == 3) begin
          if (wel) mem[alo] = spi_tx_o;
          else proto_err = 1;
          busy_left = cfg_busy;
        end
        pos++;
        pending = 1;
        dcnt = $urandom % 4;
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  logic [7:0] exp_mem [256];
  logic [7:0] exp_b [64];
  int exp_len [16];
  int exp_nfr, exp_nb;

  function automatic string ftag(bit wr, int f, int nfr);
    if (!wr) return "R7";
    if (f == 0) return "R3";
    if (f == 1) return "R4";
    if (f == nfr - 1) return "R6";
    return "R5";
  endfunction

  task automatic add_frame(input logic [7:0] b0, b1, b2, b3, input int n);
    logic [7:0] bs [4];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    exp_len[exp_nfr] = n;
    exp_nfr++;
    for (int i = 0; i < n; i++) begin
      exp_b[exp_nb] = bs[i];
      exp_nb++;
    end
  endtask

  task automatic run_txn(bit wr, logic [15:0] addr, logic [7:0] data, int busy_polls, bit inject);
    int ndone = 0, polls, wait_cyc = 0, ao = 0, eo = 0;
    logic [7:0] got_rd = 0, exp_rd;
    bit got_to = 0, exp_to;
    exp_nfr = 0; exp_nb = 0;
    exp_to = 0;
    exp_rd = exp_mem[addr[7:0]];
    if (wr) begin
      polls = (busy_polls + 1 < POLL_MAX) ? busy_polls + 1 : POLL_MAX;
      exp_to = (busy_polls >= POLL_MAX);
      add_frame(8'h06, 0, 0, 0, 1);
      add_frame(8'h02, addr[15:8], addr[7:0], data, 4);
      for (int p = 0; p < polls; p++) add_frame(8'h05, 8'h00, 0, 0, 2);
      add_frame(8'h04, 0, 0, 0, 1);
      exp_mem[addr[7:0]] = data;
    end else begin
      add_frame(8'h03, addr[15:8], addr[7:0], 8'h00, 4);
    end
    act_nfr = 0; act_nb = 0; proto_err = 0;
    cfg_busy = busy_polls;
    @(negedge clk_i);
    chk(busy_o == 0, "R2", "idle before request", busy_o, 0);
    req_valid_i = 1; req_write_i = wr; req_addr_i = addr; req_wdata_i = data;
    @(negedge clk_i);
    req_valid_i = 0;
    chk(busy_o == 1, "R2", "busy after accept", busy_o, 1);
    if (inject) begin
      req_valid_i = 1; req_write_i = ~wr; req_addr_i = ~addr; req_wdata_i = ~data;
    end
    while (busy_o && wait_cyc < 20000) begin
      if (done_o) begin
        ndone++;
        got_rd = rdata_o;
        got_to = timeout_o;
      end else if (timeout_o) begin
        chk(0, "R10", "timeout outside done", 1, 0);
      end
      @(negedge clk_i);
      wait_cyc++;
      if (wait_cyc == 3) req_valid_i = 0;
    end
    req_valid_i = 0;
    chk(ndone == 1, "R11", "done pulses", ndone, 1);
    chk(got_to == exp_to, "R10", "timeout flag", got_to, exp_to);
    if (!wr) chk(got_rd == exp_rd, "R7", "read data", got_rd, exp_rd);
    chk(proto_err == 0, "R8", "start while cs high or pending", proto_err, 0);
    chk(act_nfr == exp_nfr, wr ? "R5" : "R7", "frame count", act_nfr, exp_nfr);
    for (int f = 0; f < exp_nfr && f < act_nfr && f < 16; f++) begin
      chk(act_len[f] == exp_len[f], ftag(wr, f, exp_nfr), "frame length", act_len[f], exp_len[f]);
      for (int i = 0; i < exp_len[f] && i < act_len[f]; i++)
        if (ao + i < 64 && eo + i < 64)
          chk(act_b[ao+i] == exp_b[eo+i], ftag(wr, f, exp_nfr), "frame byte", act_b[ao+i], exp_b[eo+i]);
      ao += act_len[f];
      eo += exp_len[f];
    end
    // R1 idle after completion
    chk(cs_no == 1 && spi_start_o == 0 && done_o == 0, "R1", "idle outputs", {cs_no, spi_start_o, done_o}, 3'b100);
  endtask

  initial begin
    int s;
    s = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cs_no == 1 && busy_o == 0 && done_o == 0 && spi_start_o == 0, "R1", "reset outputs",
        {cs_no, busy_o, done_o, spi_start_o}, 4'b1000);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
    chk(cs_no == 1 && busy_o == 0 && spi_start_o == 0, "R1", "idle after reset",
        {cs_no, busy_o, spi_start_o}, 3'b100);

    // directed corners
    run_txn(1, 16'h0010, 8'hAA, 0, 0);
    run_txn(0, 16'h0010, 8'h00, 0, 0);
    run_txn(1, 16'hFFFF, 8'h5C, POLL_MAX - 1, 0);
    run_txn(0, 16'hFFFF, 8'h00, 0, 1);
    run_txn(1, 16'h0000, 8'h3B, POLL_MAX, 0);
    run_txn(1, 16'h0001, 8'hC4, POLL_MAX + 3, 1);
    run_txn(0, 16'h0000, 8'h00, 0, 0);
    run_txn(0, 16'h0001, 8'h00, 0, 0);

    // constrained random
    for (int t = 0; t < 60; t++) begin
      bit wr;
      logic [15:0] a;
      wr = $urandom % 2;
      a = 16'($urandom);
      run_txn(wr, a, 8'($urandom), $urandom % POLL_MAX, ($urandom % 4) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule